// File: doc/BRIEF.md
# MDIO Command Controller

This block is a management-bus master for Clause 22 PHY access. Software sees two 32-bit registers: a command register at offset 0x00 and a data register at offset 0x04. To write a PHY register, software loads the 16-bit value into the data register. It then writes the command word with the busy bit set. To read one, it writes only the command word. The block runs one complete 64-bit management frame on the MDC and MDIO pins. It clears the busy bit when the frame ends, and software polls that bit to find out when the transaction is finished.

MDC is divided down from the host clock. A clock-range field in the command word sets the divisor, so one divider serves a wide span of host frequencies. During a read, the block stops driving MDIO at the turnaround. It samples the PHY's 16 data bits on rising MDC edges and leaves the result in the data register.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, both registers read as zero, and MDC and the MDIO output enable are low.
- R2: The command word stores the PHY address in bits 25:21, the register number in bits 20:16, the clock range in bits 11:8, the operation code in bits 3:2 and busy in bit 0. All other bits read as zero.
- R3: A command write with bit 0 set and operation code 01 (write) or 11 (read) sets busy and starts a frame. With any other operation code, the fields are stored, busy stays 0 and no MDC edge occurs.
- R4: MDC has a period of D host cycles. It is low for the first D/2 cycles and high for the last D/2 cycles of each bit. D is 42, 62, 16, 26, 102 or 124 for clock-range codes 0 to 5, and 124 for every other code.
- R5: Every frame carries, MSB first and one bit per MDC period: 32 ones, start bits 01, opcode 10 for a read or 01 for a write, the 5-bit PHY address, the 5-bit register number, two turnaround bits and 16 data bits.
- R6: A write frame drives MDIO for all 64 bits. The turnaround is 10 and the data bits come from the data register. MDIO output is 0 whenever the output enable is low.
- R7: A read frame releases the output enable from bit 46 onward. MDIO input is captured at each rising MDC edge of bits 48 to 63, and the 16 captured bits are in the data register when busy clears.
- R8: Busy reads 1 from the cycle after the accepting write. It returns to 0 exactly 64·D host cycles later.
- R9: A command write while busy is 1 is ignored, and the running frame continues unchanged.
- R10: The data register holds the low 16 bits of a write to offset 0x04 and reads its upper 16 bits as zero.
- R11: While busy is 0, MDC and the MDIO output enable stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register byte offset (0x00 command, 0x04 data) |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for the addressed register (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | MDIO value to drive |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value from the pad |

## Verification
The bench targets the boundaries of a frame:
- **Completion cycle.** A busy bit cleared one divider period early or late shows up as a mismatch in the exact cycle 64·D after acceptance.
- **Read turnaround.** Releasing the output enable at bit 47 instead of 46 would collide with the PHY. This appears as an enable mismatch in the bit 46 period.
- **Sampling edge.** A design that samples on the falling edge, or shifts in the wrong order, leaves a corrupted value in the data register.

Further tests cover the rest:
- **Divisor selection.** Each clock range is exercised, including a reserved code. A wrong table entry changes every MDC edge.
- **Rejected commands.** Commands with a bad opcode must leave MDC quiet. A command written mid-frame must change neither the stored fields nor the running frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_BIT     = 46;
  localparam int DATA_BIT   = 48;
  localparam int DATA_W     = 16;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b11;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic shiftBit;
    logic sampleIn;
    logic finish;
  } mdioStrobeT;

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SEL_W      = 4,
  parameter int NUM_RANGES = 6,
  parameter logic [NUM_RANGES*CNT_W-1:0] DIV_LIST =
    {8'd124, 8'd102, 8'd26, 8'd16, 8'd62, 8'd42},
  parameter logic [CNT_W-1:0] DIV_RSVD = 8'd124
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             launch,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             isRead,
  output mdioStrobeT       strobe,
  output logic             mdc,
  output logic             mdioOe
);

  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);
  localparam logic [BIT_W-1:0] TA_IDX   = BIT_W'(TA_BIT);
  localparam logic [BIT_W-1:0] DATA_IDX = BIT_W'(DATA_BIT);

  logic             running;
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] divisor;
  logic [CNT_W-1:0] halfCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             lastPhase;

  // divisor lookup; reserved codes fall back to the slowest setting
  always_comb begin
    divisor = DIV_RSVD;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (clkSel == SEL_W'(i)) divisor = DIV_LIST[i*CNT_W +: CNT_W];
    end
  end

  assign halfCnt   = divisor >> 1;
  assign lastPhase = (divCnt == divisor - 1'b1);

  always_comb begin
    strobe.shiftBit = running && lastPhase && (bitIdx != LAST_BIT);
    strobe.finish   = running && lastPhase && (bitIdx == LAST_BIT);
    strobe.sampleIn = running && isRead && (bitIdx >= DATA_IDX) &&
                      (divCnt == halfCnt - 1'b1);
  end

  assign mdc    = running && (divCnt >= halfCnt);
  assign mdioOe = running && !(isRead && (bitIdx >= TA_IDX));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      divCnt  <= '0;
      bitIdx  <= '0;
    end else if (launch) begin
      running <= 1'b1;
      divCnt  <= '0;
      bitIdx  <= '0;
    end else if (running) begin
      if (lastPhase) begin
        divCnt <= '0;
        if (bitIdx == LAST_BIT) running <= 1'b0;
        else                    bitIdx  <= bitIdx + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int SEL_W  = 4,
  parameter logic [ADDR_W-1:0] CMD_OFF  = 4'h0,
  parameter logic [ADDR_W-1:0] DATA_OFF = 4'h4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  mdioStrobeT        strobe,
  input  logic              mdioIn,
  output logic              launch,
  output logic [SEL_W-1:0]  clkSel,
  output logic              isRead,
  output logic              frameMsb,
  output logic              busy,
  output logic [31:0]       cmdWord
);

  logic [4:0]            phyAddr;
  logic [4:0]            regNum;
  logic [1:0]            opCode;
  logic [DATA_W-1:0]     dataReg;
  logic [DATA_W-1:0]     rdShift;
  logic [FRAME_BITS-1:0] frameSh;
  logic                  cmdHit;
  logic                  dataHit;
  logic                  wrOpValid;
  logic [1:0]            frameOp;
  logic                  wrUnused;

  assign cmdHit    = regWrEn && (regAddr == CMD_OFF);
  assign dataHit   = regWrEn && (regAddr == DATA_OFF);
  assign wrOpValid = (regWrData[3:2] == OP_WRITE) || (regWrData[3:2] == OP_READ);
  assign launch    = cmdHit && !busy && regWrData[0] && wrOpValid;
  assign frameOp   = (regWrData[3:2] == OP_READ) ? 2'b10 : 2'b01;
  assign wrUnused  = ^{regWrData[31:26], regWrData[15:12], regWrData[7:4], regWrData[1]};

  assign isRead   = (opCode == OP_READ);
  assign frameMsb = frameSh[FRAME_BITS-1];
  assign cmdWord  = {6'b0, phyAddr, regNum, 4'b0, clkSel, 4'b0, opCode, 1'b0, busy};

  always_comb begin
    if (regAddr == CMD_OFF)       regRdData = cmdWord;
    else if (regAddr == DATA_OFF) regRdData = {16'b0, dataReg};
    else                          regRdData = '0;
  end

  // command word and data register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phyAddr <= '0;
      regNum  <= '0;
      clkSel  <= '0;
      opCode  <= '0;
      busy    <= 1'b0;
      dataReg <= '0;
    end else begin
      if (cmdHit && !busy) begin
        phyAddr <= regWrData[25:21];
        regNum  <= regWrData[20:16];
        clkSel  <= regWrData[11:8];
        opCode  <= regWrData[3:2];
        busy    <= launch;
      end
      if (dataHit) dataReg <= regWrData[DATA_W-1:0];
      if (strobe.finish) begin
        busy <= 1'b0;
        if (isRead) dataReg <= rdShift;
      end
    end
  end

  // outgoing frame and incoming data shifters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSh <= '0;
      rdShift <= '0;
    end else begin
      if (launch)
        frameSh <= {32'hFFFF_FFFF, 2'b01, frameOp, regWrData[25:21],
                    regWrData[20:16], 2'b10, dataReg};
      else if (strobe.shiftBit)
        frameSh <= {frameSh[FRAME_BITS-2:0], 1'b0};
      if (strobe.sampleIn)
        rdShift <= {rdShift[DATA_W-2:0], mdioIn};
    end
  end

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
  import mdio_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 8,
  parameter int SEL_W      = 4,
  parameter int NUM_RANGES = 6,
  parameter logic [NUM_RANGES*CNT_W-1:0] DIV_LIST =
    {8'd124, 8'd102, 8'd26, 8'd16, 8'd62, 8'd42},
  parameter logic [CNT_W-1:0] DIV_RSVD = 8'd124
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  mdioStrobeT       strobe;
  logic             launch;
  logic [SEL_W-1:0] clkSel;
  logic             isRead;
  logic             frameMsb;
  logic             busy;
  logic [31:0]      cmdWord;

  mdio_ctrl #(
    .CNT_W(CNT_W), .SEL_W(SEL_W), .NUM_RANGES(NUM_RANGES),
    .DIV_LIST(DIV_LIST), .DIV_RSVD(DIV_RSVD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .launch(launch), .clkSel(clkSel),
    .isRead(isRead), .strobe(strobe), .mdc(mdc), .mdioOe(mdioOe)
  );

  mdio_dpath #(
    .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .strobe(strobe),
    .mdioIn(mdioIn), .launch(launch), .clkSel(clkSel), .isRead(isRead),
    .frameMsb(frameMsb), .busy(busy), .cmdWord(cmdWord)
  );

  assign mdioOut = mdioOe & frameMsb;

endmodule

// File: rtl/mdio_cmd_ctrl_chk.sv
module mdio_cmd_ctrl_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              mdc,
  input logic              mdioOe,
  input logic              busy,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       cmdWord
);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  assert_launch_drives_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (mdioOe && !mdc));

  assert_ignore_cmd_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && (regAddr == '0)) |=> $stable(cmdWord[31:1]));

  assert_release_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(mdioOe)) |-> !mdioOe);

  assert_mdc_in_frame_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> busy);

endmodule

bind mdio_cmd_ctrl mdio_cmd_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .mdc(mdc), .mdioOe(mdioOe), .busy(busy),
  .regWrEn(regWrEn), .regAddr(regAddr), .cmdWord(cmdWord)
);

// File: tb/mdio_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module mdio_cmd_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = 4'h0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  int nChecks = 0;
  int nFail   = 0;

  // reference model state
  bit          active = 0;
  bit          launchNow = 0;
  int          k = 0;
  int          mDiv = 16;
  bit          mRead = 0;
  logic [63:0] mFrame = '0;
  logic [15:0] phyResp = '0;

  always #10 clk = ~clk;

  mdio_cmd_ctrl u_mdio_cmd_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int refDiv(input int sel);
    case (sel)
      0: return 42;
      1: return 62;
      2: return 16;
      3: return 26;
      4: return 102;
      5: return 124;
      default: return 124;
    endcase
  endfunction

  function automatic logic [31:0] mkCmd(input logic [4:0] phy, input logic [4:0] rg,
                                        input logic [3:0] sel, input logic [1:0] op,
                                        input logic bsy);
    return {6'b0, phy, rg, 4'b0, sel, 4'b0, op, 1'b0, bsy};
  endfunction

  // model time base
  always @(posedge clk) begin
    if (launchNow) begin
      active = 1;
      k = 0;
    end else if (active) begin
      if (k >= 64*mDiv) active = 0;
      else k++;
    end
  end

  // per-cycle comparison and PHY response
  always @(negedge clk) begin
    if (active) begin
      int bitN;
      int ph;
      logic eMdc, eOe, eOut;
      bitN = k / mDiv;
      ph   = k % mDiv;
      if (k < 64*mDiv) begin
        eMdc = (ph >= mDiv/2);
        eOe  = !(mRead && bitN >= 46);
        eOut = eOe ? mFrame[63-bitN] : 1'b0;
        mdioIn = (mRead && bitN >= 48) ? phyResp[15-(bitN-48)] : 1'b1;
        chk("R4 mdc", {31'b0, mdc}, {31'b0, eMdc});
        chk("R7 mdioOe", {31'b0, mdioOe}, {31'b0, eOe});
        chk("R5 mdioOut", {31'b0, mdioOut}, {31'b0, eOut});
        chk("R8 busy set", {31'b0, regRdData[0]}, 32'd1);
      end else begin
        mdioIn = 1'b1;
        chk("R8 busy cleared", {31'b0, regRdData[0]}, 32'd0);
        chk("R11 idle mdc/oe", {30'b0, mdc, mdioOe}, 32'd0);
      end
    end
  end

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 4'h0;
  endtask

  task automatic startFrame(input logic [4:0] phy, input logic [4:0] rg, input logic [3:0] sel,
                            input bit rd, input logic [15:0] dat, input logic [15:0] resp);
    if (!rd) wrReg(4'h4, {16'hDEAD, dat});
    phyResp = resp;
    mDiv    = refDiv(int'(sel));
    mRead   = rd;
    mFrame  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, dat};
    @(negedge clk);
    regAddr = 4'h0; regWrData = mkCmd(phy, rg, sel, rd ? 2'b11 : 2'b01, 1'b1);
    regWrEn = 1'b1; launchNow = 1;
    @(negedge clk);
    regWrEn = 1'b0; launchNow = 0;
  endtask

  task automatic waitIdle();
    while (active) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic readData(input string req, input logic [31:0] exp);
    @(negedge clk);
    regAddr = 4'h4;
    @(negedge clk);
    chk(req, regRdData, exp);
    regAddr = 4'h0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 cmd reset", regRdData, 32'h0);
    chk("R1 pins reset", {30'b0, mdc, mdioOe}, 32'd0);
    regAddr = 4'h4;
    @(negedge clk);
    chk("R1 data reset", regRdData, 32'h0);
    regAddr = 4'h0;
    rstN = 1'b1;
    @(negedge clk);

    // R10: data register holds low 16 bits
    wrReg(4'h4, 32'hFFFF_A5C3);
    readData("R10 data readback", 32'h0000_A5C3);

    // R2: field layout, no busy bit requested
    wrReg(4'h0, 32'hFFFF_FFFF & ~32'h1 & mkCmd(5'h15, 5'h0A, 4'h3, 2'b11, 1'b0) | 32'hFC00_F0F2);
    chk("R2 cmd readback", regRdData, mkCmd(5'h15, 5'h0A, 4'h3, 2'b11, 1'b0));

    // R3: invalid operation code with busy requested
    wrReg(4'h0, mkCmd(5'h07, 5'h11, 4'h2, 2'b10, 1'b1));
    chk("R3 bad op stored, not busy", regRdData, mkCmd(5'h07, 5'h11, 4'h2, 2'b10, 1'b0));
    repeat (40) @(negedge clk);
    chk("R3 no mdc after bad op", {30'b0, mdc, mdioOe}, 32'd0);
    wrReg(4'h0, mkCmd(5'h07, 5'h11, 4'h2, 2'b00, 1'b1));
    repeat (40) @(negedge clk);
    chk("R3 op 00 no frame", {30'b0, mdc, mdioOe, regRdData[0]}, 32'd0);

    // R6: write frames at different ranges
    startFrame(5'h01, 5'h1F, 4'h2, 0, 16'hBEEF, 16'h0);
    waitIdle();
    startFrame(5'h1A, 5'h05, 4'h1, 0, 16'h0F31, 16'h0);
    waitIdle();

    // R7: read frames
    startFrame(5'h1E, 5'h02, 4'h3, 1, 16'h0, 16'h6D93);
    waitIdle();
    readData("R7 read data", 32'h0000_6D93);
    startFrame(5'h00, 5'h1F, 4'h4, 1, 16'h0, 16'h8001);
    waitIdle();
    readData("R7 read data edge bits", 32'h0000_8001);

    // R9: command write while busy is ignored
    startFrame(5'h0C, 5'h13, 4'h0, 1, 16'h0, 16'h3C5A);
    repeat (300) @(negedge clk);
    regWrData = mkCmd(5'h1F, 5'h1F, 4'h5, 2'b01, 1'b1);
    regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    chk("R9 cmd unchanged while busy", regRdData, mkCmd(5'h0C, 5'h13, 4'h0, 2'b11, 1'b1));
    waitIdle();
    readData("R9 frame completed intact", 32'h0000_3C5A);

    // R4: reserved and top ranges
    startFrame(5'h12, 5'h09, 4'h9, 0, 16'h5AA5, 16'h0);
    waitIdle();
    startFrame(5'h03, 5'h0E, 4'h5, 0, 16'h7E81, 16'h0);
    waitIdle();

    chk("R11 idle at end", {30'b0, mdc, mdioOe}, 32'd0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule